// File: doc/BRIEF.md
# Deferred Condition-Code Flag Evaluator

This block keeps an arithmetic operation in a deferred form and works out the N, Z, V and C condition flags of a 32-bit datapath only when they are needed. The stored form holds three things: an operation kind, the result word and the source operand. The other operand is never stored. When the flags are needed, it is recovered from the result and the source by adding or subtracting them again. A flush strobe turns the pending record into a resolved flag word. After a flush, the record holds the resolved kind and its result word carries the flags. A second flush therefore returns the same flags.

A second path performs multi-word extend arithmetic. It adds or subtracts two words together with the extend bit X. It then updates X from the new carry or borrow and resolves the flags at once. The zero flag is sticky on this path: it can only stay set or be cleared. A chain of words therefore reports zero only when every word in the chain was zero.

Top module: `ccf_flag_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `flags_o`, `x_o`, `err_o` and `ext_res_o` and stores the resolved kind with a zero result. Flag word layout is C at bit 0, V at bit 1, Z at bit 2 and N at bit 3.
- R2: For every defined kind other than resolved, Z is set when the result (at the kind's width) is zero, and N is set when that result is nonzero with its top bit set, so N and Z are never both set.
- R3: Kind 2 (add): C is set when the result is unsigned-less than the source. V is set when the recovered operand (result minus source) and the source share a sign that differs from the result's sign.
- R4: Kind 3 (subtract): the minuend is recovered as result plus source. C is set when the minuend is unsigned-less than the source. V is set when the minuend differs in sign from both the source and the result.
- R5: Kind 4 and kind 5 compare at 8 and 16 bits respectively. They apply the subtract rule of R4 to the low byte or low halfword only, and N, Z, C and V all come from that width; the upper bits have no effect.
- R6: Kind 6 (add with extend) uses result minus source minus one as the recovered operand, and sets C when the result is unsigned-at-most the source. Kind 7 (subtract with extend) uses result plus source plus one as the minuend, and sets C when the minuend is unsigned-at-most the source.
- R7: Kind 1 (logic) clears C and V. Kind 8 (shift) clears V and sets C exactly when the stored source is nonzero.
- R8: Kind 0 (resolved) takes the flags from result bits 3..0. After a successful flush, the stored kind is 0 and the result holds the flag word, so a repeated flush leaves the flags unchanged.
- R9: A flush of an undefined kind (9 to 15) raises `err_o` for exactly one cycle and changes neither the flags nor the stored record, so a later flush raises it again.
- R10: An extend operation with `ext_sub` low produces a plus b plus X, and with it high produces a minus b minus X. It sets X to the carry-out or the borrow and evaluates the flags as kind 6/7 when X was set, or kind 2/3 otherwise.
- R11: On an extend operation the new Z is the computed Z ANDed with the previous Z, so a nonzero word earlier in a chain keeps Z clear.
- R12: `flags_o` and `x_o` change only on a flush or an extend operation. Within one cycle an extend operation takes precedence over a load, and a load takes precedence over a flush. The lower-priority strobes in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Store a new deferred record |
| ld_tag | input | 4 | Operation kind of the record |
| ld_result | input | 32 | Result word of the record |
| ld_src | input | 32 | Source operand of the record |
| flush | input | 1 | Resolve the stored record into flags |
| ext_valid | input | 1 | Run one extend arithmetic step |
| ext_sub | input | 1 | Extend step subtracts when high, adds when low |
| ext_a | input | 32 | Extend step first operand |
| ext_b | input | 32 | Extend step second operand (kept as source) |
| flags_o | output | 4 | Resolved flag word {N,Z,V,C} |
| x_o | output | 1 | Extend flag |
| err_o | output | 1 | One-cycle pulse on flush of an undefined kind |
| ext_res_o | output | 32 | Result of the last extend step |

## Verification
The sticky-zero behaviour is the hardest case to reach from the ports. The extend-carry variants also need X already set, which only a prior extend step with a carry or borrow can do. The directed stimulus first loads a resolved Z through a kind-0 record. It then runs an add that wraps to zero to set X, followed by zero-valued steps. This shows Z cleared by one nonzero word and then never set again. A long randomized phase adds to this. It mixes loads of every kind (undefined ones included), flushes, extend steps and simultaneous strobes, with operands drawn heavily from 0, the sign boundary and all-ones. A behavioural model built on 64-bit integer arithmetic predicts every output on every cycle.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

  localparam int TAG_W = 4;
  localparam int FLG_W = 4;

  // flag word bit positions
  localparam int FLG_C = 0;
  localparam int FLG_V = 1;
  localparam int FLG_Z = 2;
  localparam int FLG_N = 3;

  typedef enum logic [TAG_W-1:0] {
    CC_RESOLVED = 4'd0,
    CC_LOGIC    = 4'd1,
    CC_ADD      = 4'd2,
    CC_SUB      = 4'd3,
    CC_CMP8     = 4'd4,
    CC_CMP16    = 4'd5,
    CC_ADDX     = 4'd6,
    CC_SUBX     = 4'd7,
    CC_SHIFT    = 4'd8
  } cc_tag_e;

  localparam logic [TAG_W-1:0] CC_LAST_DEFINED = 4'd8;

  // number of compare/arith lanes and their widths
  localparam int N_LANES  = 3;
  localparam int LANE_B   = 0;
  localparam int LANE_H   = 1;
  localparam int LANE_F   = 2;

endpackage

// File: rtl/ccf_lane.sv
// One width slice: sign/zero detection plus carry and overflow recovery
// for both the add and the subtract family, with an optional carry-in.
module ccf_lane #(
  parameter int LW = 32
) (
  input  logic [LW-1:0] res,
  input  logic [LW-1:0] src,
  input  logic          cin,
  output logic          n,
  output logic          z,
  output logic          c_add,
  output logic          v_add,
  output logic          c_sub,
  output logic          v_sub
);

  localparam int MSB = LW - 1;

  logic [LW-1:0] cin_w;
  logic [LW-1:0] opnd_add;   // recovered first operand of an add
  logic [LW-1:0] minuend;    // recovered minuend of a subtract
  logic [LW-1:0] v_add_vec;
  logic [LW-1:0] v_sub_vec;

  always_comb begin
    cin_w     = {{(LW-1){1'b0}}, cin};
    opnd_add  = res - src - cin_w;
    minuend   = res + src + cin_w;

    z         = (res == '0);
    n         = res[MSB];

    c_add     = cin ? (res <= src) : (res < src);
    v_add_vec = (src ^ res) & ~(opnd_add ^ src);
    v_add     = v_add_vec[MSB];

    c_sub     = cin ? (minuend <= src) : (minuend < src);
    v_sub_vec = (minuend ^ res) & (minuend ^ src);
    v_sub     = v_sub_vec[MSB];
  end

endmodule

// File: rtl/ccf_flag_eval.sv
// Combinational evaluation of a deferred record into a flag word.
module ccf_flag_eval
  import ccf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [TAG_W-1:0] tag,
  input  logic [DW-1:0]    res,
  input  logic [DW-1:0]    src,
  output logic [FLG_W-1:0] flags,
  output logic             bad_tag
);

  logic [N_LANES-1:0] l_n, l_z, l_ca, l_va, l_cs, l_vs;
  logic               ext_kind;

  assign ext_kind = (tag == CC_ADDX) || (tag == CC_SUBX);

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam int LW = (g == LANE_B) ? 8 : (g == LANE_H) ? 16 : DW;
    logic lane_cin;
    if (g == LANE_F) begin : g_cin_full
      assign lane_cin = ext_kind;
    end else begin : g_cin_zero
      assign lane_cin = 1'b0;
    end
    ccf_lane #(.LW(LW)) u_lane (
      .res   (res[LW-1:0]),
      .src   (src[LW-1:0]),
      .cin   (lane_cin),
      .n     (l_n[g]),
      .z     (l_z[g]),
      .c_add (l_ca[g]),
      .v_add (l_va[g]),
      .c_sub (l_cs[g]),
      .v_sub (l_vs[g])
    );
  end

  function automatic logic [FLG_W-1:0] pack(input logic fn, input logic fz,
                                            input logic fv, input logic fc);
    logic [FLG_W-1:0] w;
    w        = '0;
    w[FLG_N] = fn;
    w[FLG_Z] = fz;
    w[FLG_V] = fv;
    w[FLG_C] = fc;
    return w;
  endfunction

  always_comb begin
    bad_tag = 1'b0;
    flags   = '0;
    case (tag)
      CC_RESOLVED: flags = res[FLG_W-1:0];
      CC_LOGIC:    flags = pack(l_n[LANE_F], l_z[LANE_F], 1'b0, 1'b0);
      CC_ADD,
      CC_ADDX:     flags = pack(l_n[LANE_F], l_z[LANE_F], l_va[LANE_F], l_ca[LANE_F]);
      CC_SUB,
      CC_SUBX:     flags = pack(l_n[LANE_F], l_z[LANE_F], l_vs[LANE_F], l_cs[LANE_F]);
      CC_CMP8:     flags = pack(l_n[LANE_B], l_z[LANE_B], l_vs[LANE_B], l_cs[LANE_B]);
      CC_CMP16:    flags = pack(l_n[LANE_H], l_z[LANE_H], l_vs[LANE_H], l_cs[LANE_H]);
      CC_SHIFT:    flags = pack(l_n[LANE_F], l_z[LANE_F], 1'b0, |src);
      default:     bad_tag = 1'b1;
    endcase
  end

endmodule

// File: rtl/ccf_ext_arith.sv
// Multi-word extend step: a +/- b +/- X, new X, and the record kind it implies.
module ccf_ext_arith
  import ccf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  logic             sub_op,
  input  logic             x_in,
  output logic [DW-1:0]    res,
  output logic             x_out,
  output logic [TAG_W-1:0] tag
);

  logic [DW:0] sum_w;
  logic [DW:0] dif_w;
  logic [DW:0] x_w;

  always_comb begin
    x_w   = {{DW{1'b0}}, x_in};
    sum_w = {1'b0, a} + {1'b0, b} + x_w;
    dif_w = {1'b0, a} - {1'b0, b} - x_w;
    if (sub_op) begin
      res   = dif_w[DW-1:0];
      x_out = dif_w[DW];
      tag   = x_in ? CC_SUBX : CC_SUB;
    end else begin
      res   = sum_w[DW-1:0];
      x_out = sum_w[DW];
      tag   = x_in ? CC_ADDX : CC_ADD;
    end
  end

endmodule

// File: rtl/ccf_flag_unit.sv
module ccf_flag_unit
  import ccf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_valid,
  input  logic [TAG_W-1:0] ld_tag,
  input  logic [DW-1:0]    ld_result,
  input  logic [DW-1:0]    ld_src,
  input  logic             flush,
  input  logic             ext_valid,
  input  logic             ext_sub,
  input  logic [DW-1:0]    ext_a,
  input  logic [DW-1:0]    ext_b,
  output logic [FLG_W-1:0] flags_o,
  output logic             x_o,
  output logic             err_o,
  output logic [DW-1:0]    ext_res_o
);

  localparam int PAD_W = DW - FLG_W;

  // stored deferred record
  logic [TAG_W-1:0] tag_q;
  logic [DW-1:0]    res_q;
  logic [DW-1:0]    src_q;
  logic [FLG_W-1:0] flags_q;
  logic             x_q;
  logic             err_q;
  logic [DW-1:0]    ext_res_q;

  // flush path
  logic [FLG_W-1:0] fl_flags;
  logic             fl_bad;

  // extend path
  logic [DW-1:0]    ex_res;
  logic             ex_x;
  logic [TAG_W-1:0] ex_tag;
  logic [FLG_W-1:0] ex_flags_raw;
  logic [FLG_W-1:0] ex_flags;
  logic             ex_bad;

  ccf_flag_eval #(.DW(DW)) u_eval_flush (
    .tag     (tag_q),
    .res     (res_q),
    .src     (src_q),
    .flags   (fl_flags),
    .bad_tag (fl_bad)
  );

  ccf_ext_arith #(.DW(DW)) u_ext (
    .a      (ext_a),
    .b      (ext_b),
    .sub_op (ext_sub),
    .x_in   (x_q),
    .res    (ex_res),
    .x_out  (ex_x),
    .tag    (ex_tag)
  );

  ccf_flag_eval #(.DW(DW)) u_eval_ext (
    .tag     (ex_tag),
    .res     (ex_res),
    .src     (ext_b),
    .flags   (ex_flags_raw),
    .bad_tag (ex_bad)
  );

  // sticky zero across a chain of extend steps
  always_comb begin
    ex_flags        = ex_flags_raw;
    ex_flags[FLG_Z] = ex_flags_raw[FLG_Z] & flags_q[FLG_Z];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q     <= CC_RESOLVED;
      res_q     <= '0;
      src_q     <= '0;
      flags_q   <= '0;
      x_q       <= 1'b0;
      err_q     <= 1'b0;
      ext_res_q <= '0;
    end else begin
      err_q <= 1'b0;
      if (ext_valid) begin
        ext_res_q <= ex_res;
        x_q       <= ex_x;
        flags_q   <= ex_flags;
        tag_q     <= CC_RESOLVED;
        res_q     <= {{PAD_W{1'b0}}, ex_flags};
        src_q     <= ext_b;
      end else if (ld_valid) begin
        tag_q <= ld_tag;
        res_q <= ld_result;
        src_q <= ld_src;
      end else if (flush) begin
        if (fl_bad) begin
          err_q <= 1'b1;
        end else begin
          flags_q <= fl_flags;
          tag_q   <= CC_RESOLVED;
          res_q   <= {{PAD_W{1'b0}}, fl_flags};
        end
      end
    end
  end

  assign flags_o   = flags_q;
  assign x_o       = x_q;
  assign err_o     = err_q;
  assign ext_res_o = ext_res_q;

  logic unused_ok;
  assign unused_ok = ex_bad;

endmodule

// File: rtl/ccf_flag_unit_chk.sv
module ccf_flag_unit_chk
  import ccf_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             ld_valid,
  input logic             flush,
  input logic             ext_valid,
  input logic [FLG_W-1:0] flags_o,
  input logic             x_o,
  input logic             err_o,
  input logic [TAG_W-1:0] tag_q
);

  logic flush_only;
  assign flush_only = flush && !ext_valid && !ld_valid;

  // R12: flags and X stay put without a flush or extend step
  p_quiet_flags_r12: assert property (@(posedge clk) disable iff (rst)
    (!ext_valid && !flush) |=> ($stable(flags_o) && $stable(x_o)));

  // R10: X moves only on an extend step
  p_x_only_ext_r10: assert property (@(posedge clk) disable iff (rst)
    !ext_valid |=> $stable(x_o));

  // R2: evaluated non-resolved kinds never give N and Z together
  p_nz_excl_r2: assert property (@(posedge clk) disable iff (rst)
    (flush_only && tag_q != CC_RESOLVED && tag_q <= CC_LAST_DEFINED)
      |=> !(flags_o[FLG_N] && flags_o[FLG_Z]));

  // R8: a good flush leaves the record in resolved form
  p_resolved_after_r8: assert property (@(posedge clk) disable iff (rst)
    (flush_only && tag_q <= CC_LAST_DEFINED) |=> (tag_q == CC_RESOLVED));

  // R9: undefined kind raises the error and keeps the record
  p_bad_tag_err_r9: assert property (@(posedge clk) disable iff (rst)
    (flush_only && tag_q > CC_LAST_DEFINED) |=> (err_o && $stable(tag_q)));

  // R9: error pulse never coincides with a flag change
  p_err_holds_r9: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $stable(flags_o));

  // R11: an extend step cannot raise Z
  p_sticky_z_r11: assert property (@(posedge clk) disable iff (rst)
    (ext_valid && !flags_o[FLG_Z]) |=> !flags_o[FLG_Z]);

endmodule

bind ccf_flag_unit ccf_flag_unit_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .ld_valid  (ld_valid),
  .flush     (flush),
  .ext_valid (ext_valid),
  .flags_o   (flags_o),
  .x_o       (x_o),
  .err_o     (err_o),
  .tag_q     (tag_q)
);

// File: tb/ccf_flag_unit_tb_top.sv
`timescale 1ns/1ps
module ccf_flag_unit_tb_top;

  localparam int DW = 32;
  localparam longint MASK32 = 64'h0000_0000_FFFF_FFFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_valid = 1'b0;
  logic [3:0]    ld_tag = '0;
  logic [DW-1:0] ld_result = '0;
  logic [DW-1:0] ld_src = '0;
  logic          flush = 1'b0;
  logic          ext_valid = 1'b0;
  logic          ext_sub = 1'b0;
  logic [DW-1:0] ext_a = '0;
  logic [DW-1:0] ext_b = '0;
  logic [3:0]    flags_o;
  logic          x_o;
  logic          err_o;
  logic [DW-1:0] ext_res_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ccf_flag_unit #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_tag(ld_tag),
    .ld_result(ld_result), .ld_src(ld_src), .flush(flush),
    .ext_valid(ext_valid), .ext_sub(ext_sub), .ext_a(ext_a), .ext_b(ext_b),
    .flags_o(flags_o), .x_o(x_o), .err_o(err_o), .ext_res_o(ext_res_o)
  );

  // ---------------- behavioural reference model ----------------
  int        m_tag;
  longint    m_res, m_src, m_eres;
  bit        m_x, m_err;
  bit [3:0]  m_flags;

  function automatic longint sgn(longint v, int w);
    longint one = 1;
    return (v >= (one << (w - 1))) ? v - (one << w) : v;
  endfunction

  function automatic bit [3:0] m_eval(int tag, longint r_in, longint s_in, output bit is_bad);
    longint one = 1;
    int w;
    longint mask, r, s, a, m, t, lim;
    bit n, z, v, c;
    is_bad = 1'b0;
    w    = (tag == 4) ? 8 : (tag == 5) ? 16 : 32;
    mask = (one << w) - 1;
    lim  = one << (w - 1);
    r = r_in & mask;
    s = s_in & mask;
    n = (r >= lim);
    z = (r == 0);
    v = 1'b0;
    c = 1'b0;
    case (tag)
      0: return r_in[3:0];
      1: ;
      2, 6: begin
        t = (tag == 6) ? 1 : 0;
        a = (r - s - t) & mask;
        c = (a + s + t) > mask;
        v = ((sgn(a, w) + sgn(s, w) + t) >= lim) || ((sgn(a, w) + sgn(s, w) + t) < -lim);
      end
      3, 4, 5, 7: begin
        t = (tag == 7) ? 1 : 0;
        m = (r + s + t) & mask;
        c = (m - s - t) < 0;
        v = ((sgn(m, w) - sgn(s, w) - t) >= lim) || ((sgn(m, w) - sgn(s, w) - t) < -lim);
      end
      8: c = (s_in != 0);
      default: begin
        is_bad = 1'b1;
        return 4'h0;
      end
    endcase
    return {n, z, v, c};
  endfunction

  task automatic model_step();
    bit       b;
    bit [3:0] f;
    longint   a, bb, k, d;
    if (rst) begin
      m_tag = 0; m_res = 0; m_src = 0; m_eres = 0;
      m_x = 1'b0; m_err = 1'b0; m_flags = 4'h0;
      return;
    end
    m_err = 1'b0;
    if (ext_valid) begin
      a  = longint'(ext_a);
      bb = longint'(ext_b);
      k  = m_x ? 1 : 0;
      if (ext_sub) begin
        d = a - bb - k;
        f = m_eval(m_x ? 7 : 3, d & MASK32, bb, b);
        m_x = (d < 0);
      end else begin
        d = a + bb + k;
        f = m_eval(m_x ? 6 : 2, d & MASK32, bb, b);
        m_x = (d > MASK32);
      end
      f[2]    = f[2] & m_flags[2];
      m_flags = f;
      m_eres  = d & MASK32;
      m_tag   = 0;
      m_res   = longint'(f);
      m_src   = bb;
    end else if (ld_valid) begin
      m_tag = int'(ld_tag);
      m_res = longint'(ld_result);
      m_src = longint'(ld_src);
    end else if (flush) begin
      f = m_eval(m_tag, m_res, m_src, b);
      if (b) m_err = 1'b1;
      else begin
        m_flags = f;
        m_tag   = 0;
        m_res   = longint'(f);
      end
    end
  endtask

  // ---------------- checking ----------------
  task automatic check_val(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    total++;
    if (flags_o !== m_flags || x_o !== m_x || err_o !== m_err ||
        longint'(ext_res_o) != m_eres) begin
      bad++;
      $display("FAIL %s model: actual flags=%0h x=%0b err=%0b res=%0h expected flags=%0h x=%0b err=%0b res=%0h",
               req, flags_o, x_o, err_o, ext_res_o, m_flags, m_x, m_err, m_eres);
    end
  endtask

  task automatic tick(string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(req);
    ld_valid  = 1'b0;
    flush     = 1'b0;
    ext_valid = 1'b0;
  endtask

  task automatic do_ld(int tag, logic [31:0] r, logic [31:0] s, string req);
    ld_valid = 1'b1; ld_tag = 4'(tag); ld_result = r; ld_src = s;
    tick(req);
  endtask

  task automatic do_flush(string req);
    flush = 1'b1;
    tick(req);
  endtask

  task automatic do_ext(bit sub, logic [31:0] a, logic [31:0] b, string req);
    ext_valid = 1'b1; ext_sub = sub; ext_a = a; ext_b = b;
    tick(req);
  endtask

  task automatic eval_expect(int tag, logic [31:0] r, logic [31:0] s, logic [3:0] exp, string req);
    do_ld(tag, r, s, req);
    do_flush(req);
    check_val(req, "flags", longint'(flags_o), longint'(exp));
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      4: return 32'(($urandom_range(0, 3)));
      5: return {24'($urandom), 8'h80};
      default: return 32'($urandom);
    endcase
  endfunction

  function automatic string req_of(int tag);
    case (tag)
      0: return "R8";
      1, 8: return "R7";
      2: return "R3";
      3: return "R4";
      4, 5: return "R5";
      6, 7: return "R6";
      default: return "R9";
    endcase
  endfunction

  // ---------------- stimulus ----------------
  initial begin
    int tg;
    repeat (3) @(posedge clk);
    model_step();
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    compare("R1");
    check_val("R1", "flags", longint'(flags_o), 0);
    check_val("R1", "x", longint'(x_o), 0);
    check_val("R1", "err", longint'(err_o), 0);

    // R3 add
    eval_expect(2, 32'h0000_0000, 32'h0000_0001, 4'h5, "R3");
    eval_expect(2, 32'h8000_0000, 32'h7FFF_FFFF, 4'hA, "R3");
    // R4 subtract
    eval_expect(3, 32'hFFFF_FFFF, 32'h0000_0001, 4'h9, "R4");
    // R5 byte/halfword compare, upper bits ignored
    eval_expect(4, 32'hABCD_127F, 32'hFFFF_FF01, 4'h2, "R5");
    eval_expect(5, 32'h1234_0000, 32'h9999_0001, 4'h4, "R5");
    // R6 extend variants
    eval_expect(6, 32'h0000_0005, 32'h0000_0005, 4'h1, "R6");
    eval_expect(7, 32'hFFFF_FFFF, 32'h0000_0000, 4'h9, "R6");
    // R7 logic and shift; R2 N/Z exclusive
    eval_expect(8, 32'h0000_0000, 32'h0000_0002, 4'h5, "R7");
    eval_expect(8, 32'h8000_0000, 32'h0000_0000, 4'h8, "R7");
    eval_expect(1, 32'h8000_0000, 32'hFFFF_FFFF, 4'h8, "R2");
    // R8 resolved kind and repeat flush
    eval_expect(0, 32'hFFFF_FFFF, 32'h0, 4'hF, "R8");
    do_flush("R8");
    check_val("R8", "flags repeat", longint'(flags_o), 15);
    eval_expect(3, 32'hFFFF_FFFF, 32'h1, 4'h9, "R8");
    do_flush("R8");
    check_val("R8", "flags repeat", longint'(flags_o), 9);
    // R9 undefined kind
    do_ld(12, 32'h0, 32'h5, "R9");
    do_flush("R9");
    check_val("R9", "err", longint'(err_o), 1);
    check_val("R9", "flags kept", longint'(flags_o), 9);
    tick("R9");
    check_val("R9", "err pulse", longint'(err_o), 0);
    do_flush("R9");
    check_val("R9", "err again", longint'(err_o), 1);

    // R10 / R11 extend chain
    eval_expect(0, 32'h4, 32'h0, 4'h4, "R11");
    do_ext(1'b0, 32'hFFFF_FFFF, 32'h1, "R10");
    check_val("R10", "res", longint'(ext_res_o), 0);
    check_val("R10", "x", longint'(x_o), 1);
    check_val("R10", "flags", longint'(flags_o), 5);
    do_ext(1'b0, 32'h0, 32'h0, "R10");
    check_val("R10", "res with X", longint'(ext_res_o), 1);
    check_val("R10", "x", longint'(x_o), 0);
    check_val("R11", "flags", longint'(flags_o), 0);
    do_ext(1'b0, 32'h0, 32'h0, "R11");
    check_val("R11", "Z sticky clear", longint'(flags_o), 0);
    do_ext(1'b1, 32'h0, 32'h1, "R10");
    check_val("R10", "sub res", longint'(ext_res_o), 32'hFFFF_FFFF);
    check_val("R10", "sub flags", longint'(flags_o), 9);
    do_ext(1'b1, 32'h5, 32'h4, "R10");
    check_val("R10", "subx res", longint'(ext_res_o), 0);
    check_val("R10", "subx x", longint'(x_o), 0);
    check_val("R11", "subx Z sticky", longint'(flags_o), 0);

    // R12 priority: extend beats load and flush
    ld_valid = 1'b1; ld_tag = 4'd2; ld_result = 32'h0; ld_src = 32'h1; flush = 1'b1;
    do_ext(1'b0, 32'h7FFF_FFFF, 32'h1, "R12");
    check_val("R12", "ext wins", longint'(flags_o), 4'hA);
    do_flush("R12");
    check_val("R12", "load dropped", longint'(flags_o), 4'hA);
    // load beats flush
    ld_valid = 1'b1; ld_tag = 4'd8; ld_result = 32'h0; ld_src = 32'h1; flush = 1'b1;
    tick("R12");
    check_val("R12", "flush dropped", longint'(flags_o), 4'hA);
    do_flush("R12");
    check_val("R12", "loaded shift", longint'(flags_o), 4'h5);

    // randomized mix, compared against the model every cycle
    for (int i = 0; i < 6000; i++) begin
      tg = ($urandom_range(0, 9) == 0) ? $urandom_range(9, 15) : $urandom_range(0, 8);
      ld_valid  = ($urandom_range(0, 2) == 0);
      ld_tag    = 4'(tg);
      ld_result = pick();
      ld_src    = pick();
      flush     = ($urandom_range(0, 1) == 0);
      ext_valid = ($urandom_range(0, 3) == 0);
      ext_sub   = $urandom_range(0, 1) == 1;
      ext_a     = pick();
      ext_b     = pick();
      if (ext_valid) tick("R10");
      else if (ld_valid) tick("R12");
      else tick(req_of(tg));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule